// File: doc/BRIEF.md
# Full-Bridge Chopping Gate Controller

This block is the digital core that steers the four gate controls of one full-bridge winding driver: an upper (source) and a lower (sink) switch on each of the two bridge legs, A and B. A direction input picks which diagonal pair conducts. Every direction change is followed by a window in which all four switches are off, so that the two switches of one leg never overlap.

While the bridge conducts, the block regulates the winding current at a fixed chopping rate. Each tick of an external oscillator starts a new on-time. A current-comparator trip ends the on-time, but only after a blanking window has passed since that tick. In the off part of a chop period only the source switch opens and the sink stays closed, so the current decays slowly by recirculation. A separate disable input opens all four switches at once, which gives fast decay. A regulation-enable input turns chopping off, so that the switches follow direction and disable alone. A thermal fault opens all four switches and holds them open until a cooled flag reports that the die has fallen below the hysteresis point.

Top module: `hbridge_chop_ctrl`

## Requirements
- R1: With `dir_i`=1, the block enabled, no fault and no dead window, the outputs {src_a,snk_a,src_b,snk_b} are 4'b1001 while the source is allowed to conduct.
- R2: With `dir_i`=0 under the same conditions, the outputs are 4'b0110.
- R3: When `dir_i` differs from the value sampled at the previous clock edge, all four outputs are 0 in that same cycle. They stay 0 for DEAD_CYC further clock edges and the new diagonal turns on after edge DEAD_CYC+1.
- R4: While `dis_i` is 1, all four outputs are 0 in the same cycle, whatever the chopping state.
- R5: With `reg_en_i`=1, a clock edge that samples `osc_tick_i`=1 turns the source of the selected diagonal on from the next cycle.
- R6: A `trip_i` sampled during the BLANK_CYC edges that follow the tick edge has no effect: the source stays on.
- R7: A `trip_i` sampled at any later edge turns the source off from the next cycle. The diagonal sink stays on (slow decay), giving 4'b0001 for dir 1 and 4'b0100 for dir 0.
- R8: With `reg_en_i`=0, the source follows only direction, disable, dead time and fault, and ignores ticks and trips.
- R9: `therm_hot_i`=1 forces all outputs to 0 in the same cycle. After it falls, the outputs stay 0 until an edge samples `therm_cool_i`=1 with `therm_hot_i`=0.
- R10: The source and the sink of the same leg are never 1 together.
- R11: While `rst_n` is 0, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Direction: 1 drives leg A to leg B |
| dis_i | input | 1 | 1 opens all four switches |
| trip_i | input | 1 | Current-comparator trip |
| osc_tick_i | input | 1 | One-cycle chopping oscillator tick |
| reg_en_i | input | 1 | 1 enables internal current chopping |
| therm_hot_i | input | 1 | Over-temperature flag |
| therm_cool_i | input | 1 | Cooled-below-hysteresis flag |
| src_a_o | output | 1 | Leg A source gate |
| snk_a_o | output | 1 | Leg A sink gate |
| src_b_o | output | 1 | Leg B source gate |
| snk_b_o | output | 1 | Leg B sink gate |

## Verification
A wrong dead-time counter shows at the ports as a diagonal that turns on one or more cycles early or late after a direction change, or as a cycle in which both legs' switches overlap. A corrupted blanking count or on-time flag shows within one chop period as a source that opens during blanking or never opens after a trip. A stuck fault latch keeps the bridge dark after the cooled flag. Each of these departs from the reference model in the first cycle it occurs.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
    typedef struct packed {
        logic src_a;
        logic snk_a;
        logic src_b;
        logic snk_b;
    } hbc_drive_t;

    localparam hbc_drive_t HBC_ALL_OFF = '{default: 1'b0};
endpackage

// File: rtl/hbc_deadtime.sv
module hbc_deadtime #(
    parameter int DEAD_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_i,
    output logic dir_o,
    output logic dead_o
);
    localparam int DW = $clog2(DEAD_CYC + 1);

    typedef struct packed {
        logic          dir;
        logic [DW-1:0] cnt;
    } dt_state_t;

    dt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dir_i != st_q.dir) begin
            st_d.dir = dir_i;
            st_d.cnt = DW'(DEAD_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_o  = st_q.dir;
    assign dead_o = (st_q.cnt != '0) || (dir_i != st_q.dir);
endmodule

// File: rtl/hbc_chopper.sv
module hbc_chopper #(
    parameter int BLANK_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic trip_i,
    output logic on_o
);
    localparam int BW = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        logic          on;
        logic [BW-1:0] blank;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.on    = 1'b1;
            st_d.blank = BW'(BLANK_CYC);
        end else if (st_q.blank != '0) begin
            st_d.blank = st_q.blank - 1'b1;
        end else if (trip_i) begin
            st_d.on = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_o = st_q.on;
endmodule

// File: rtl/hbc_thermal.sv
module hbc_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    input  logic cool_i,
    output logic fault_o
);
    logic fault_d, fault_q;

    always_comb begin
        fault_d = fault_q;
        if (hot_i)       fault_d = 1'b1;
        else if (cool_i) fault_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_d;
    end

    assign fault_o = hot_i | fault_q;
endmodule

// File: rtl/hbridge_chop_ctrl.sv
module hbridge_chop_ctrl
    import hbc_pkg::*;
#(
    parameter int DEAD_CYC  = 50,
    parameter int BLANK_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_i,
    input  logic dis_i,
    input  logic trip_i,
    input  logic osc_tick_i,
    input  logic reg_en_i,
    input  logic therm_hot_i,
    input  logic therm_cool_i,
    output logic src_a_o,
    output logic snk_a_o,
    output logic src_b_o,
    output logic snk_b_o
);
    logic       dir_held, dead, chop_on, fault;
    logic       bridge_en, src_en;
    hbc_drive_t drv;

    hbc_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk(clk), .rst_n(rst_n), .dir_i(dir_i),
        .dir_o(dir_held), .dead_o(dead)
    );

    hbc_chopper #(.BLANK_CYC(BLANK_CYC)) u_chop (
        .clk(clk), .rst_n(rst_n), .tick_i(osc_tick_i),
        .trip_i(trip_i), .on_o(chop_on)
    );

    hbc_thermal u_therm (
        .clk(clk), .rst_n(rst_n), .hot_i(therm_hot_i),
        .cool_i(therm_cool_i), .fault_o(fault)
    );

    always_comb begin
        bridge_en = rst_n && !dis_i && !fault && !dead;
        src_en    = bridge_en && (chop_on || !reg_en_i);
        drv       = HBC_ALL_OFF;
        if (dir_held) begin
            drv.src_a = src_en;
            drv.snk_b = bridge_en;
        end else begin
            drv.src_b = src_en;
            drv.snk_a = bridge_en;
        end
    end

    assign src_a_o = drv.src_a;
    assign snk_a_o = drv.snk_a;
    assign src_b_o = drv.src_b;
    assign snk_b_o = drv.snk_b;
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker (
    input logic clk,
    input logic rst_n,
    input logic dir_i,
    input logic dis_i,
    input logic therm_hot_i,
    input logic src_a_o,
    input logic snk_a_o,
    input logic src_b_o,
    input logic snk_b_o
);
    logic any_on;
    assign any_on = src_a_o | snk_a_o | src_b_o | snk_b_o;

    AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_a_o && snk_a_o)); // R10
    AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_b_o && snk_b_o)); // R10
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |-> !any_on); // R4
    AST_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        therm_hot_i |-> !any_on); // R9
    AST_DIR_FLIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_i != $past(dir_i)) |-> !any_on); // R3
    AST_SRC_A_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
        src_a_o |-> snk_b_o); // R1
    AST_SRC_B_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
        src_b_o |-> snk_a_o); // R2
    AST_RESET_OFF: assert property (@(posedge clk)
        !rst_n |-> !any_on); // R11
endmodule

bind hbridge_chop_ctrl hbc_checker u_hbc_checker (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .dis_i(dis_i),
    .therm_hot_i(therm_hot_i), .src_a_o(src_a_o), .snk_a_o(snk_a_o),
    .src_b_o(src_b_o), .snk_b_o(snk_b_o)
);

// File: tb/hbridge_chop_ctrl_bench.sv
`timescale 1ns/1ps
module hbridge_chop_ctrl_bench;
    localparam int DEAD  = 50;
    localparam int BLANK = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dir_i = 1'b0, dis_i = 1'b0, trip_i = 1'b0, osc_tick_i = 1'b0;
    logic reg_en_i = 1'b0, therm_hot_i = 1'b0, therm_cool_i = 1'b0;
    logic src_a_o, snk_a_o, src_b_o, snk_b_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hbridge_chop_ctrl #(.DEAD_CYC(DEAD), .BLANK_CYC(BLANK)) u_hbridge_chop_ctrl (
        .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .dis_i(dis_i), .trip_i(trip_i),
        .osc_tick_i(osc_tick_i), .reg_en_i(reg_en_i), .therm_hot_i(therm_hot_i),
        .therm_cool_i(therm_cool_i), .src_a_o(src_a_o), .snk_a_o(snk_a_o),
        .src_b_o(src_b_o), .snk_b_o(snk_b_o)
    );

    function automatic logic [3:0] outs();
        return {src_a_o, snk_a_o, src_b_o, snk_b_o};
    endfunction

    // Behavioural reference model
    int m_dir = 0, m_dead_left = 0, m_on = 0, m_blank_left = 0, m_hot_latch = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0; m_dead_left = 0; m_on = 0; m_blank_left = 0; m_hot_latch = 0;
        end else begin
            if (int'(dir_i) != m_dir) begin
                m_dir = int'(dir_i);
                m_dead_left = DEAD;
            end else if (m_dead_left > 0) m_dead_left--;
            if (osc_tick_i) begin
                m_on = 1; m_blank_left = BLANK;
            end else if (m_blank_left > 0) m_blank_left--;
            else if (trip_i) m_on = 0;
            if (therm_hot_i) m_hot_latch = 1;
            else if (therm_cool_i) m_hot_latch = 0;
        end
    end

    function automatic logic [3:0] model_out();
        bit sink, src;
        if (!rst_n || dis_i || therm_hot_i || m_hot_latch != 0) return 4'b0000;
        if (m_dead_left > 0 || int'(dir_i) != m_dir) return 4'b0000;
        sink = 1'b1;
        src  = !reg_en_i || (m_on != 0);
        return (m_dir != 0) ? {src, 1'b0, 1'b0, sink} : {1'b0, sink, src, 1'b0};
    endfunction

    function automatic string model_req();
        if (!rst_n) return "R11";
        if (dis_i) return "R4";
        if (therm_hot_i || m_hot_latch != 0) return "R9";
        if (m_dead_left > 0 || int'(dir_i) != m_dir) return "R3";
        if (!reg_en_i) return "R8";
        return (m_on != 0) ? "R5/R6" : "R7";
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (outs() !== model_out()) begin
                errors++;
                $display("FAIL %s model compare t=%0t actual=%b expected=%b",
                         model_req(), $time, outs(), model_out());
            end
            checks++;
            if ((src_a_o && snk_a_o) || (src_b_o && snk_b_o)) begin
                errors++;
                $display("FAIL R10 leg overlap actual=%b expected=no overlap", outs());
            end
        end
    end

    task automatic chk(input string req, input logic [3:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, outs(), exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #5000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        edges(3);
        chk("R11", 4'b0000);
        dir_i = 1'b1;
        edges(1);
        rst_n = 1'b1;
        edges(DEAD + 4);
        chk("R1", 4'b1001);
        dir_i = 1'b0;
        #1 chk("R3", 4'b0000);
        edges(DEAD);
        chk("R3", 4'b0000);
        edges(1);
        chk("R2", 4'b0110);
        dir_i = 1'b1;
        edges(DEAD + 1);
        chk("R3", 4'b1001);
        dis_i = 1'b1;
        #1 chk("R4", 4'b0000);
        edges(3);
        dis_i = 1'b0;
        #1 chk("R4", 4'b1001);
        therm_hot_i = 1'b1;
        #1 chk("R9", 4'b0000);
        edges(2);
        therm_hot_i = 1'b0;
        edges(5);
        chk("R9", 4'b0000);
        therm_cool_i = 1'b1;
        edges(1);
        therm_cool_i = 1'b0;
        chk("R9", 4'b1001);
        reg_en_i = 1'b1;
        #1 chk("R5", 4'b0001);
        osc_tick_i = 1'b1;
        edges(1);
        osc_tick_i = 1'b0;
        trip_i = 1'b1;
        chk("R5", 4'b1001);
        edges(BLANK);
        chk("R6", 4'b1001);
        edges(1);
        chk("R7", 4'b0001);
        trip_i = 1'b0;
        reg_en_i = 1'b0;
        #1 chk("R8", 4'b1001);
        trip_i = 1'b1;
        edges(3);
        chk("R8", 4'b1001);
        trip_i = 1'b0;
        reg_en_i = 1'b1;
        dir_i = 1'b0;
        osc_tick_i = 1'b1;
        edges(1);
        osc_tick_i = 1'b0;
        trip_i = 1'b1;
        edges(DEAD + 1);
        chk("R7", 4'b0100);
        trip_i = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            dir_i        = ($urandom_range(0, 59) == 0) ? ~dir_i : dir_i;
            dis_i        = ($urandom_range(0, 29) == 0);
            osc_tick_i   = (i % 70 == 0);
            trip_i       = ($urandom_range(0, 3) == 0);
            reg_en_i     = ($urandom_range(0, 199) == 0) ? ~reg_en_i : reg_en_i;
            therm_hot_i  = ($urandom_range(0, 499) == 0);
            therm_cool_i = ($urandom_range(0, 19) == 0);
            edges(1);
        end
        rst_n = 1'b0;
        #1 chk("R11", 4'b0000);
        edges(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule